// File: doc/BRIEF.md
# Dual-Edge Data Checksum Accumulator

This block is the receive-side self-test adder for a link that carries two interleaved streams of 16-bit words. Each incoming word carries an edge flag telling whether it was sent in the rising-edge slot or in the falling-edge slot. The block keeps one running sum for each slot. Software can use these sums to confirm that a known pattern arrived intact: it sends the pattern, takes a snapshot, and compares the two sums with the values the same pattern gave before.

All control goes through a byte-wide register port. One control byte holds three action bits: clear, enable and snapshot. Four read-only result bytes show the most recent snapshot of both sums. A test run follows this order. First the clear bit is set and then released, which zeroes both sums. Next the enable bit is set and the pattern is sent. Then the snapshot bit is written together with enable, and the result bytes are read. Zero words arriving after the pattern do not change the sums.

Top module: `edge_sum_selftest`

## Requirements
- R1: After reset the control byte, both running sums and both snapshots are zero, so every register address reads 0x00.
- R2: The control byte at address 0x1A reads back the last byte written to it. Bit 7 is enable, bit 6 is snapshot and bit 5 is clear. A write takes effect on the clock edge at which it is presented.
- R3: A valid word is added only while the stored control byte has bit 7 set and bit 5 clear. A word presented in the same cycle as the write that sets enable is not added. With enable clear, words leave both sums unchanged.
- R4: A word with edge flag 0 is added to the rising-edge sum only. A word with edge flag 1 is added to the falling-edge sum only. A zero word leaves its sum unchanged.
- R5: Each sum is 16 bits wide and wraps modulo 2^16.
- R6: While the stored control byte has bit 5 set, both running sums are forced to zero, even if bit 7 is also set. Writing 0x20 and then 0x00 therefore leaves both sums at zero.
- R7: A write to 0x1A with bit 6 set copies both running sums, as they were before that clock edge, into the snapshots. The rising-edge snapshot reads at 0x1B (low byte) and 0x1C (high byte). The falling-edge snapshot reads at 0x1D (low byte) and 0x1E (high byte).
- R8: Between snapshot writes, the result bytes keep their value even while the running sums change.
- R9: Writes to any address other than 0x1A have no effect. Reads of any address other than 0x1A to 0x1E return 0x00.
- R10: The same word sequence, sent after a clear, always gives the same snapshot values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Word present this cycle |
| smp_fall | input | 1 | Edge flag: 0 rising-edge slot, 1 falling-edge slot |
| smp_data | input | 16 | Incoming word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for reg_addr (combinational) |

## Verification
The running sums are visible at the ports only through a snapshot. If a running sum is wrong, or a word is added to the wrong slot, the error appears in the result bytes read after the next snapshot write, and no earlier. A wrong snapshot register or a wrong control byte shows up in reg_rdata in the same cycle its address is presented. For that reason the bench compares reg_rdata against its own model in every cycle, and reads the result bytes right after each snapshot, after runs with enable clear, after clears, after counts that wrap, and after writes to other addresses.

// File: rtl/edge_sum_pkg.sv
`timescale 1ns/1ps
package edge_sum_pkg;

  // Number of edge slots, and the slot each flag value selects.
  localparam int NUM_EDGES = 2;

  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  // Positions of the action bits in the control byte.
  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_RD_BIT  = 6;
  localparam int CTRL_CLR_BIT = 5;

  // Addition reduced to w bits. Requires w < 64.
  function automatic logic [63:0] wrap_add(input logic [63:0] a,
                                           input logic [63:0] b,
                                           input int w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (a + b) & mask;
  endfunction

  // Address of byte idx in the result window that starts at base.
  function automatic int result_addr(input int base, input int lane,
                                     input int nbytes, input int idx);
    return base + lane * nbytes + idx;
  endfunction

endpackage

// File: rtl/edge_sum_ctrl.sv
`timescale 1ns/1ps
module edge_sum_ctrl
  import edge_sum_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_q,
  output logic              snap_evt,
  output logic              clr_active,
  output logic              acc_en
);

  logic ctrl_wr;

  assign ctrl_wr    = reg_we && (reg_addr == CTRL_ADDR);
  assign snap_evt   = ctrl_wr && reg_wdata[CTRL_RD_BIT];
  assign clr_active = ctrl_q[CTRL_CLR_BIT];
  assign acc_en     = ctrl_q[CTRL_EN_BIT] && !ctrl_q[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
    end else if (ctrl_wr) begin
      ctrl_q <= reg_wdata;
    end
  end

endmodule

// File: rtl/edge_sum_lane.sv
`timescale 1ns/1ps
module edge_sum_lane
  import edge_sum_pkg::*;
#(
  parameter int   DATA_W   = 16,
  parameter int   SUM_W    = 16,
  parameter logic LANE_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_fall,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              acc_en,
  input  logic              clr_active,
  input  logic              snap_evt,
  output logic [SUM_W-1:0]  acc_q,
  output logic [SUM_W-1:0]  snap_q,
  output logic              hit
);

  logic [SUM_W-1:0] acc_next;

  assign hit      = acc_en && smp_valid && (smp_fall == LANE_SEL);
  assign acc_next = SUM_W'(wrap_add(64'(acc_q), 64'(smp_data), SUM_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr_active) begin
      acc_q <= '0;
    end else if (hit) begin
      acc_q <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_evt) begin
      snap_q <= acc_q;
    end
  end

endmodule

// File: rtl/edge_sum_rdmux.sv
`timescale 1ns/1ps
module edge_sum_rdmux
  import edge_sum_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SUM_W  = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [7:0]                 ctrl_q,
  input  logic [NUM_EDGES*SUM_W-1:0] snap_flat,
  output logic [7:0]                 reg_rdata
);

  localparam int NBYTES   = SUM_W / 8;
  localparam int RES_BASE = int'(CTRL_ADDR) + 1;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata = ctrl_q;
    end
    for (int e = 0; e < NUM_EDGES; e++) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (reg_addr == ADDR_W'(result_addr(RES_BASE, e, NBYTES, b))) begin
          reg_rdata = snap_flat[e*SUM_W + b*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/edge_sum_selftest.sv
`timescale 1ns/1ps
module edge_sum_selftest
  import edge_sum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_fall,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);

  logic [7:0]                 ctrl_q;
  logic                       snap_evt;
  logic                       clr_active;
  logic                       acc_en;
  logic [NUM_EDGES*SUM_W-1:0] acc_flat;
  logic [NUM_EDGES*SUM_W-1:0] snap_flat;
  logic [NUM_EDGES-1:0]       hit_vec;

  // Named views for the checker.
  logic [SUM_W-1:0] acc_rise;
  logic [SUM_W-1:0] acc_fall;
  logic [SUM_W-1:0] snap_rise;
  logic [SUM_W-1:0] snap_fall;

  edge_sum_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl_q    (ctrl_q),
    .snap_evt  (snap_evt),
    .clr_active(clr_active),
    .acc_en    (acc_en)
  );

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_lane
    edge_sum_lane #(
      .DATA_W  (DATA_W),
      .SUM_W   (SUM_W),
      .LANE_SEL(1'(e))
    ) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_fall  (smp_fall),
      .smp_data  (smp_data),
      .acc_en    (acc_en),
      .clr_active(clr_active),
      .snap_evt  (snap_evt),
      .acc_q     (acc_flat[e*SUM_W +: SUM_W]),
      .snap_q    (snap_flat[e*SUM_W +: SUM_W]),
      .hit       (hit_vec[e])
    );
  end

  assign acc_rise  = acc_flat[int'(EDGE_RISE)*SUM_W +: SUM_W];
  assign acc_fall  = acc_flat[int'(EDGE_FALL)*SUM_W +: SUM_W];
  assign snap_rise = snap_flat[int'(EDGE_RISE)*SUM_W +: SUM_W];
  assign snap_fall = snap_flat[int'(EDGE_FALL)*SUM_W +: SUM_W];

  edge_sum_rdmux #(
    .ADDR_W   (ADDR_W),
    .SUM_W    (SUM_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) rdmux_i (
    .reg_addr (reg_addr),
    .ctrl_q   (ctrl_q),
    .snap_flat(snap_flat),
    .reg_rdata(reg_rdata)
  );

endmodule

// File: rtl/edge_sum_chk.sv
`timescale 1ns/1ps
module edge_sum_chk #(
  parameter int SUM_W  = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_fall,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        ctrl_q,
  input logic              snap_evt,
  input logic              clr_active,
  input logic              acc_en,
  input logic [1:0]        hit_vec,
  input logic [SUM_W-1:0]  acc_rise,
  input logic [SUM_W-1:0]  acc_fall,
  input logic [SUM_W-1:0]  snap_rise,
  input logic [SUM_W-1:0]  snap_fall
);

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == CTRL_ADDR) |=> (ctrl_q == $past(reg_wdata)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr_active) |=> ($stable(acc_rise) && $stable(acc_fall)));

  p_route_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && smp_valid && !smp_fall) |=> $stable(acc_fall));

  p_route_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && smp_valid && smp_fall) |=> $stable(acc_rise));

  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> (acc_rise == '0 && acc_fall == '0));

  p_snap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> (snap_rise == $past(acc_rise) && snap_fall == $past(acc_fall)));

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> ($stable(snap_rise) && $stable(snap_fall)));

  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != CTRL_ADDR) |=> $stable(ctrl_q));

endmodule

bind edge_sum_selftest edge_sum_chk #(
  .SUM_W    (SUM_W),
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_fall  (smp_fall),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ctrl_q    (ctrl_q),
  .snap_evt  (snap_evt),
  .clr_active(clr_active),
  .acc_en    (acc_en),
  .hit_vec   (hit_vec),
  .acc_rise  (acc_rise),
  .acc_fall  (acc_fall),
  .snap_rise (snap_rise),
  .snap_fall (snap_fall)
);

// File: tb/edge_sum_selftest_tb_top.sv
`timescale 1ns/1ps
module edge_sum_selftest_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_fall = 1'b0;
  logic [15:0] smp_data = 16'h0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [7:0]  reg_wdata = 8'h0;
  logic [7:0]  reg_rdata;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_sum_selftest dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_fall (smp_fall),
    .smp_data (smp_data),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Behavioural reference: plain integers, updated on each rising edge.
  int m_ctrl = 0;
  int m_acc[2] = '{0, 0};
  int m_snap[2] = '{0, 0};

  always @(posedge clk) begin
    int old_acc[2];
    old_acc = m_acc;
    if (!rst_n) begin
      m_ctrl = 0; m_acc = '{0, 0}; m_snap = '{0, 0};
    end else begin
      if (reg_we && reg_addr == 8'h1A && reg_wdata[6]) m_snap = old_acc;
      if ((m_ctrl & 'h20) != 0) m_acc = '{0, 0};
      else if ((m_ctrl & 'h80) != 0 && smp_valid)
        m_acc[int'(smp_fall)] = (old_acc[int'(smp_fall)] + int'(smp_data)) % 65536;
      if (reg_we && reg_addr == 8'h1A) m_ctrl = int'(reg_wdata);
    end
  end

  function automatic int model_rd(input logic [7:0] a);
    case (a)
      8'h1A: return m_ctrl;
      8'h1B: return m_snap[0] & 'hFF;
      8'h1C: return (m_snap[0] >> 8) & 'hFF;
      8'h1D: return m_snap[1] & 'hFF;
      8'h1E: return (m_snap[1] >> 8) & 'hFF;
      default: return 0;
    endcase
  endfunction

  // Cycle-by-cycle comparison of the read port against the model (R7, R9).
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_tests++;
      if (int'(reg_rdata) != model_rd(reg_addr)) begin
        n_fail++;
        $display("FAIL R7 cycle compare addr=%02h actual=%02h expected=%02h",
                 reg_addr, reg_rdata, model_rd(reg_addr));
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic v, input logic f, input logic [15:0] x);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    smp_valid = v; smp_fall = f; smp_data = x;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic send(input logic f, input logic [15:0] x);
    drive(1'b0, 8'h00, 8'h00, 1'b1, f, x);
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    drive(1'b0, a, 8'h00, 1'b0, 1'b0, 16'h0);
    @(posedge clk);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic rd_sums(output int rise, output int fall);
    int lo, hi;
    rd(8'h1B, lo); rd(8'h1C, hi); rise = (hi << 8) | lo;
    rd(8'h1D, lo); rd(8'h1E, hi); fall = (hi << 8) | lo;
  endtask

  task automatic clear_and_enable();
    wr(8'h1A, 8'h20); wr(8'h1A, 8'h00); wr(8'h1A, 8'h80);
  endtask

  // Sends a pseudo-random run and returns its own sums.
  task automatic lfsr_run(output int rise, output int fall);
    logic [15:0] s;
    s = 16'hACE1;
    rise = 0; fall = 0;
    for (int i = 0; i < 64; i++) begin
      s = s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
      if (i % 7 == 3) begin
        send(s[3], 16'h0);
      end else if (s[3]) begin
        send(1'b1, s); fall = (fall + int'(s)) % 65536;
      end else begin
        send(1'b0, s); rise = (rise + int'(s)) % 65536;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, r, f, r1, f1, er, ef;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 8'h1A; a <= 8'h1E; a++) begin
      rd(8'(a), v); chk("R1 reset read", v, 0);
    end

    // R6, R3, R4: clear sequence, enable, mixed words including zeros
    clear_and_enable();
    send(1'b0, 16'h1234); send(1'b1, 16'h0101); send(1'b0, 16'h0000);
    send(1'b1, 16'h00FF); send(1'b0, 16'h1111); send(1'b1, 16'h0000);
    wr(8'h1A, 8'hC0);
    rd(8'h1B, v); chk("R7 rise low byte", v, 8'h45);
    rd(8'h1C, v); chk("R7 rise high byte", v, 8'h23);
    rd(8'h1D, v); chk("R7 fall low byte", v, 8'h00);
    rd(8'h1E, v); chk("R4 fall high byte", v, 8'h02);
    rd(8'h1A, v); chk("R2 ctrl readback", v, 8'hC0);

    // R8: sums keep changing, result bytes do not
    send(1'b0, 16'h0100); send(1'b1, 16'h0001);
    rd_sums(r, f);
    chk("R8 rise snapshot held", r, 16'h2345);
    chk("R8 fall snapshot held", f, 16'h0200);

    // R3: disabled words ignored, snapshot without enable
    wr(8'h1A, 8'h00);
    send(1'b0, 16'h5555); send(1'b1, 16'h7777);
    wr(8'h1A, 8'h40);
    rd_sums(r, f);
    chk("R3 rise unchanged while disabled", r, 16'h2445);
    chk("R3 fall unchanged while disabled", f, 16'h0201);

    // R3: word in the same cycle as the enabling write is not added
    wr(8'h1A, 8'h20); wr(8'h1A, 8'h00);
    drive(1'b1, 8'h1A, 8'h80, 1'b1, 1'b0, 16'h0F0F);
    send(1'b0, 16'h0001);
    wr(8'h1A, 8'hC0);
    rd_sums(r, f);
    chk("R3 enable-cycle word skipped", r, 16'h0001);

    // R5: wrap modulo 2^16
    clear_and_enable();
    send(1'b0, 16'hFFFF); send(1'b0, 16'h0003);
    send(1'b1, 16'h8000); send(1'b1, 16'h8001);
    wr(8'h1A, 8'hC0);
    rd_sums(r, f);
    chk("R5 rise wraps", r, 16'h0002);
    chk("R5 fall wraps", f, 16'h0001);

    // R6: clear wins over enable
    wr(8'h1A, 8'hA0);
    send(1'b0, 16'h1234); send(1'b1, 16'h4321);
    wr(8'h1A, 8'hE0);
    rd_sums(r, f);
    chk("R6 rise forced zero", r, 0);
    chk("R6 fall forced zero", f, 0);

    // R9: other addresses ignored and read as zero
    wr(8'h1A, 8'h80);
    send(1'b0, 16'h0042);
    wr(8'h1A, 8'hC0);
    wr(8'h1B, 8'h55); wr(8'h30, 8'hAA);
    rd(8'h1B, v); chk("R9 result byte not writable", v, 8'h42);
    rd(8'h30, v); chk("R9 unmapped read", v, 0);
    rd(8'h1A, v); chk("R9 ctrl untouched", v, 8'hC0);

    // R10: repeat the same run twice
    clear_and_enable();
    lfsr_run(er, ef);
    wr(8'h1A, 8'hC0);
    rd_sums(r1, f1);
    chk("R10 first run rise", r1, er);
    chk("R10 first run fall", f1, ef);
    clear_and_enable();
    lfsr_run(er, ef);
    wr(8'h1A, 8'hC0);
    rd_sums(r, f);
    chk("R10 repeat rise", r, r1);
    chk("R10 repeat fall", f, f1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule